// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit serves a vector permute operation that gathers bytes out of a table held in consecutive vector registers. A request carries a 64-bit word of eight byte indices, the number of the first table register, a table length of one to four 128-bit registers, and a 64-bit initial result. The unit walks the eight index lanes in order, one per cycle. It fetches the needed table register through a synchronous read port of a 32-entry vector register file and places the selected byte into the result lane that held the index.

The table wraps around the end of the register file: after register 31, the next table register is register 0. When an index falls outside the table, that result lane keeps its byte from the initial result. The caller therefore gets the zeroing form by passing zeros and the merging form by passing the current destination value. A one-cycle done pulse marks the moment the 64-bit result is complete. Decoding the operation and writing the result back are left to the caller.

Top module: `vtbl_lookup`

## Requirements
- R1: Out of reset, busy_o, done_o and rf_rd_en_o are 0 and result_o is all zeros.
- R2: Lane k (k = 0..7) takes its index from idx_i bits [8k+7:8k], and the byte it selects is written to result_o bits [8k+7:8k].
- R3: tbl_len_i encodes a table of tbl_len_i+1 registers (0 means 1, 3 means 4). An index is in range only when it is less than 16*(tbl_len_i+1).
- R4: Every out-of-range lane keeps the byte that init_i held in the same lane. An all-zero init_i gives zeros, and any other value is merged.
- R5: The register read for an in-range index is (base_reg_i + index[7:4]) mod 32, so a table wraps from register 31 to register 0.
- R6: Inside the register, index bit 3 picks the lower (0) or upper (1) 64-bit half, and index[2:0] picks the byte within that half. The byte is therefore read from register bits [64*index[3] + 8*index[2:0] +: 8].
- R7: The unit makes exactly one register-file read per in-range lane and none for out-of-range lanes. Read data is taken one cycle after rf_rd_en_o.
- R8: Counting the rising edge that accepts start_i as edge 1, done_o is high for exactly one cycle, right after edge 10. In that cycle busy_o is 0 and result_o holds the final value, which stays until the next accepted start.
- R9: A start_i pulse while busy_o is 1 is ignored. The operation in flight completes with its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse. It samples all request inputs when the unit is idle. |
| idx_i | input | 64 | Eight byte indices, lane k at bits [8k+7:8k] |
| base_reg_i | input | 5 | First table register |
| tbl_len_i | input | 2 | Table length minus one, in registers |
| init_i | input | 64 | Initial result; out-of-range lanes keep its bytes |
| rf_rd_en_o | output | 1 | Register-file read request |
| rf_rd_addr_o | output | 5 | Register-file read address |
| rf_rd_data_i | input | 128 | Register-file read data, valid one cycle after the request |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| result_o | output | 64 | Lookup result |

## Verification
The bench sweeps every start register from 0 to 31 against every table length, using random indices biased toward the in-range boundary. Start registers at 29 to 31 with long tables separate a correct modulo-32 wrap from an overflow into nonexistent registers. Directed patterns use ascending byte indices so that any swap of halves or bytes shows up at once. Indices equal to and one above the table limit separate the less-than test from a less-or-equal test. Alternating zero and random initial results separate the zeroing and merging forms. A counter on the read strobe catches reads issued for out-of-range lanes.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } vtbl_state_e;
endpackage

// File: rtl/vtbl_addr_gen.sv
module vtbl_addr_gen #(
  parameter int IDX_W  = 8,
  parameter int REG_AW = 5,
  parameter int LEN_W  = 2,
  parameter int OFF_W  = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [REG_AW-1:0] base_i,
  input  logic [LEN_W-1:0]  tlen_i,
  output logic              hit_o,
  output logic [REG_AW-1:0] reg_o,
  output logic [OFF_W-1:0]  byte_o
);
  logic [IDX_W:0]   limit;
  logic [IDX_W-1:0] blk;

  always_comb begin
    limit  = ({{(IDX_W+1-LEN_W){1'b0}}, tlen_i} + {{IDX_W{1'b0}}, 1'b1}) << OFF_W;
    hit_o  = {1'b0, idx_i} < limit;
    blk    = idx_i >> OFF_W;
    reg_o  = base_i + blk[REG_AW-1:0];
    byte_o = idx_i[OFF_W-1:0];
  end
endmodule

// File: rtl/vtbl_byte_pick.sv
module vtbl_byte_pick #(
  parameter int VREG_W = 128,
  parameter int OFF_W  = 4
) (
  input  logic [VREG_W-1:0] data_i,
  input  logic [OFF_W-1:0]  byte_i,
  output logic [7:0]        byte_o
);
  localparam int HALF_W = VREG_W / 2;
  localparam int HOFF_W = OFF_W - 1;

  logic [HALF_W-1:0] half [2];

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      assign half[h] = data_i[h*HALF_W +: HALF_W];
    end
  endgenerate

  logic [HALF_W-1:0] sel_half;
  logic [HOFF_W-1:0] in_half;

  always_comb begin
    sel_half = half[byte_i[OFF_W-1]];
    in_half  = byte_i[HOFF_W-1:0];
    byte_o   = sel_half[in_half*8 +: 8];
  end
endmodule

// File: rtl/vtbl_ctrl.sv
module vtbl_ctrl
  import vtbl_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wb_pend_i,
  output logic              accept_o,
  output logic              issue_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              busy_o
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  vtbl_state_e       state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;

  always_comb begin
    busy_o   = (state_q != ST_IDLE) || wb_pend_i;
    accept_o = start_i && !busy_o;
    issue_o  = (state_q == ST_ISSUE);
    state_d  = state_q;
    lane_d   = lane_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          state_d = ST_ISSUE;
          lane_d  = '0;
        end
      end
      ST_ISSUE: begin
        lane_d = lane_q + 1'b1;
        if (lane_q == LAST) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
    end
  end

  assign lane_o = lane_q;

  // R8
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> (issue_o && lane_o == $past(lane_o) + 1'b1) ||
                (!issue_o && $past(lane_o) == LAST));
endmodule

// File: rtl/vtbl_lookup.sv
module vtbl_lookup #(
  parameter int LANES  = 8,
  parameter int IDX_W  = 8,
  parameter int NREGS  = 32,
  parameter int VREG_W = 128,
  parameter int LEN_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [LANES*IDX_W-1:0]     idx_i,
  input  logic [$clog2(NREGS)-1:0]   base_reg_i,
  input  logic [LEN_W-1:0]           tbl_len_i,
  input  logic [LANES*8-1:0]         init_i,
  output logic                       rf_rd_en_o,
  output logic [$clog2(NREGS)-1:0]   rf_rd_addr_o,
  input  logic [VREG_W-1:0]          rf_rd_data_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [LANES*8-1:0]         result_o
);
  localparam int REG_AW = $clog2(NREGS);
  localparam int OFF_W  = $clog2(VREG_W / 8);
  localparam int LANE_W = $clog2(LANES);
  localparam int RES_W  = LANES * 8;
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  logic                  accept, issue;
  logic [LANE_W-1:0]     lane;
  logic [LANES*IDX_W-1:0] idx_q;
  logic [REG_AW-1:0]     base_q;
  logic [LEN_W-1:0]      tlen_q;
  logic                  hit;
  logic [REG_AW-1:0]     reg_addr;
  logic [OFF_W-1:0]      byte_sel;
  logic                  wb_vld_q, wb_hit_q;
  logic [LANE_W-1:0]     wb_lane_q;
  logic [OFF_W-1:0]      wb_byte_q;
  logic [7:0]            picked;
  logic [RES_W-1:0]      result_q, result_d;
  logic                  done_q, done_d;

  vtbl_ctrl #(.LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .wb_pend_i(wb_vld_q),
    .accept_o (accept),
    .issue_o  (issue),
    .lane_o   (lane),
    .busy_o   (busy_o)
  );

  vtbl_addr_gen #(.IDX_W(IDX_W), .REG_AW(REG_AW), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_addr (
    .idx_i (idx_q[lane*IDX_W +: IDX_W]),
    .base_i(base_q),
    .tlen_i(tlen_q),
    .hit_o (hit),
    .reg_o (reg_addr),
    .byte_o(byte_sel)
  );

  vtbl_byte_pick #(.VREG_W(VREG_W), .OFF_W(OFF_W)) u_pick (
    .data_i(rf_rd_data_i),
    .byte_i(wb_byte_q),
    .byte_o(picked)
  );

  assign rf_rd_en_o   = issue && hit;
  assign rf_rd_addr_o = reg_addr;

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      base_q <= '0;
      tlen_q <= '0;
    end else if (accept) begin
      idx_q  <= idx_i;
      base_q <= base_reg_i;
      tlen_q <= tbl_len_i;
    end
  end

  // writeback stage, aligned with the read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld_q  <= 1'b0;
      wb_hit_q  <= 1'b0;
      wb_lane_q <= '0;
      wb_byte_q <= '0;
    end else begin
      wb_vld_q <= issue;
      if (issue) begin
        wb_hit_q  <= hit;
        wb_lane_q <= lane;
        wb_byte_q <= byte_sel;
      end
    end
  end

  always_comb begin
    result_d = result_q;
    if (accept) result_d = init_i;
    else if (wb_vld_q && wb_hit_q) result_d[wb_lane_q*8 +: 8] = picked;
    done_d = wb_vld_q && (wb_lane_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en_o |-> busy_o);

  // R4
  miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld_q && !wb_hit_q) |=> $stable(result_o));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(idx_q) && $stable(base_q) && $stable(tlen_q)));
endmodule

// File: tb/test_vtbl_lookup.sv
module test_vtbl_lookup;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [63:0]  idx_i;
  logic [4:0]   base_reg_i;
  logic [1:0]   tbl_len_i;
  logic [63:0]  init_i;
  logic         rf_rd_en_o;
  logic [4:0]   rf_rd_addr_o;
  logic [127:0] rf_rd_data_i;
  logic         busy_o, done_o;
  logic [63:0]  result_o;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vtbl_lookup i_vtbl_lookup (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_i(idx_i),
    .base_reg_i(base_reg_i), .tbl_len_i(tbl_len_i), .init_i(init_i),
    .rf_rd_en_o(rf_rd_en_o), .rf_rd_addr_o(rf_rd_addr_o),
    .rf_rd_data_i(rf_rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  function automatic logic [127:0] reg_val(input int r);
    logic [127:0] v;
    for (int b = 0; b < 16; b++) v[8*b +: 8] = 8'(r*37 + b*11 + 5);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rf_rd_en_o) begin
      rf_rd_data_i <= reg_val(int'(rf_rd_addr_o));
      rd_cnt <= rd_cnt + 1;
    end
  end

  function automatic logic [63:0] model(input logic [63:0] ix, input int base,
                                        input int tl, input logic [63:0] ini,
                                        output int hits);
    logic [63:0] r = ini;
    hits = 0;
    for (int k = 0; k < 8; k++) begin
      int i = int'(ix[8*k +: 8]);
      if (i < 16*(tl+1)) begin
        int rg = (base + i/16) % 32;
        int h  = (i/8) % 2;
        int o  = i % 8;
        logic [127:0] v = reg_val(rg);
        r[8*k +: 8] = v[64*h + 8*o +: 8];
        hits++;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation; optional extra start pulse mid-run
  task automatic run(input logic [63:0] ix, input int base, input int tl,
                     input logic [63:0] ini, input bit poke, input string tag);
    logic [63:0] exp;
    int hits, cyc;
    exp = model(ix, base, tl, ini, hits);
    @(negedge clk);
    rd_cnt = 0;
    idx_i = ix; base_reg_i = 5'(base); tbl_len_i = 2'(tl); init_i = ini;
    start_i = 1'b1;
    cyc = 0;
    while (!done_o && cyc < 40) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (poke && cyc == 3) begin
        start_i = 1'b1; idx_i = ~ix; base_reg_i = 5'(base + 7); init_i = ~ini;
      end
    end
    check(cyc == 10, {"R8 latency ", tag}, 64'(cyc), 64'd10);
    check(result_o === exp, {"R2 R3 R4 R5 R6 result ", tag}, result_o, exp);
    check(rd_cnt == hits, {"R7 reads ", tag}, 64'(rd_cnt), 64'(hits));
    check(!busy_o, {"R8 idle at done ", tag}, 64'(busy_o), 64'd0);
    @(negedge clk);
    check(!done_o && result_o === exp, {"R8 single pulse, hold ", tag},
          {63'd0, done_o} ^ result_o, exp);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ix;
    start_i = 0; idx_i = '0; base_reg_i = '0; tbl_len_i = '0; init_i = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !rf_rd_en_o && result_o == 64'd0, "R1 reset",
          {busy_o, done_o, rf_rd_en_o, result_o[60:0]}, 64'd0);
    rst_n = 1;
    // R2 R6 ascending bytes, both halves of one register
    run(64'h0f0e_0b0a_0706_0100, 0, 0, 64'd0, 0, "R6 ascending");
    // R3 boundary: 15 in, 16 out for one register; 63 in, 64 out for four
    run(64'h1010_0f0f_1010_0f0f, 4, 0, 64'd0, 0, "R3 len1 edge");
    run(64'h4040_3f3f_4141_3f3f, 9, 3, 64'hdead_beef_cafe_f00d, 0, "R3 len4 edge");
    // R4 merging with all lanes out of range
    run(64'hffff_ffff_ffff_ffff, 2, 3, 64'h0123_4567_89ab_cdef, 0, "R4 all miss");
    // R5 wrap from register 31
    run(64'h3830_2820_1810_0800, 31, 3, 64'd0, 0, "R5 wrap 31");
    run(64'h3f2f_1f0f_3020_1000, 30, 3, 64'd0, 0, "R5 wrap 30");
    // R9 start while busy is ignored
    run(64'h0123_2211_3f00_1a2b, 29, 3, 64'h5555_aaaa_5555_aaaa, 1, "R9 busy start");
    // sweep all bases and lengths
    for (int b = 0; b < 32; b++) begin
      for (int t = 0; t < 4; t++) begin
        for (int rep = 0; rep < 3; rep++) begin
          for (int k = 0; k < 8; k++) begin
            ix[8*k +: 8] = ($urandom_range(0, 9) == 0) ? 8'($urandom) :
                           8'($urandom_range(0, 16*(t+1) + 3));
          end
          run(ix, b, t, (rep == 1) ? 64'd0 : {$urandom, $urandom}, 0, "R5 sweep");
        end
      end
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule